// File: doc/BRIEF.md
# Reservation Station Array with Result-Bus Wakeup

This block holds instructions that wait for one functional unit in a speculative out-of-order core. Each accepted dispatch puts an operation into a free station. It brings two source operands, each either a ready value or the reorder-buffer tag of the instruction that will produce it, and the reorder-buffer number of its own result. The stations watch the common result bus. When a broadcast tag matches a pending operand, the station copies the broadcast value.

A station whose operands are both present asks for the functional unit. When several ask, the one that has waited longest wins. The unit takes the winner over a valid/ready handshake. The station stays occupied until its own result appears on the result bus, and is free again from the next cycle. A flush input empties every station at once, for example after a branch was mispredicted. The functional unit, the reorder buffer and the register file are outside the block.

Top module: `rs_array`

## Requirements
- R1: `disp_ready` is high exactly when `flush` is low, `rob_free` is high and at least one station is free. A dispatch is accepted when `disp_valid` and `disp_ready` are both high.
- R2: An issued instruction presents on `fu_op` and `fu_dst` the operation and the destination reorder-buffer tag it was dispatched with.
- R3: An operand dispatched with its pending bit set to 1 is held as a tag. It takes `cdb_data` at the first clock edge where `cdb_valid` is high and `cdb_tag` equals that tag. An operand with its pending bit at 0 takes the dispatched value.
- R4: A pending operand whose tag is on the result bus in the cycle it is dispatched takes the bus value at the dispatch edge, so that no wakeup is lost.
- R5: `fu_valid` is high only when an occupied station that has not been issued holds both operands. It rises in the cycle after the edge that made the last operand present.
- R6: Each station keeps an age that starts at 0 at dispatch and rises by one per cycle while the station is occupied, saturating at 2^AGE_W-1. Among the ready stations the one with the largest age is offered. On equal age the lowest-numbered station wins, and a dispatch always fills the lowest-numbered free station.
- R7: While `fu_ready` is low an offered instruction is not consumed. After the cycle where `fu_valid` and `fu_ready` are both high, that station is never offered again.
- R8: An issued station is released at the edge where `cdb_valid` is high and `cdb_tag` equals its destination tag, and it can take a new dispatch from the next cycle.
- R9: While `flush` is high, `disp_ready` and `fu_valid` are low, and every station is free after that edge.
- R10: After reset no station is occupied: `fu_valid` is low and `disp_ready` follows `rob_free`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Empty all stations |
| rob_free | input | 1 | Reorder buffer has a free slot |
| disp_valid | input | 1 | Dispatch request |
| disp_ready | output | 1 | Dispatch can be accepted |
| disp_op | input | OP_W | Operation code |
| disp_dst | input | TAG_W | Destination reorder-buffer tag |
| disp_a_pend | input | 1 | Operand A waits for a tag (1) or is a value (0) |
| disp_a_tag | input | TAG_W | Operand A producer tag |
| disp_a_val | input | DATA_W | Operand A value |
| disp_b_pend | input | 1 | Operand B waits for a tag (1) or is a value (0) |
| disp_b_tag | input | TAG_W | Operand B producer tag |
| disp_b_val | input | DATA_W | Operand B value |
| cdb_valid | input | 1 | Result bus broadcast present |
| cdb_tag | input | TAG_W | Tag of the broadcast result |
| cdb_data | input | DATA_W | Broadcast result value |
| fu_valid | output | 1 | Instruction offered to the unit |
| fu_ready | input | 1 | Unit takes the offered instruction |
| fu_op | output | OP_W | Offered operation |
| fu_a | output | DATA_W | Offered operand A |
| fu_b | output | DATA_W | Offered operand B |
| fu_dst | output | TAG_W | Offered destination tag |

## Verification
Dispatch and result-bus wakeup can fall in the same cycle. An incoming operand may name the very tag being broadcast, and an occupied station may be released by that broadcast while another station is being filled. A directed case dispatches an operand pending on tag 9 while tag 9 is broadcast, and expects the operand value and `fu_valid` in the next cycle. Random traffic lets a broadcast, a dispatch and an issue meet freely, and a bench model predicts every port cycle by cycle.

// File: rtl/rs_pkg.sv
package rs_pkg;
  parameter int RS_N      = 4;
  parameter int RS_DATA_W = 32;
  parameter int RS_TAG_W  = 4;
  parameter int RS_OP_W   = 4;
  parameter int RS_AGE_W  = 4;

  typedef enum logic [1:0] {
    ST_FREE = 2'd0,
    ST_WAIT = 2'd1,
    ST_SENT = 2'd2
  } st_phase_e;
endpackage

// File: rtl/rs_operand.sv
module rs_operand #(
  parameter int DATA_W = 32,
  parameter int TAG_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              ld_pend,
  input  logic [TAG_W-1:0]  ld_tag,
  input  logic [DATA_W-1:0] ld_val,
  input  logic              cdb_valid,
  input  logic [TAG_W-1:0]  cdb_tag,
  input  logic [DATA_W-1:0] cdb_data,
  output logic              ok,
  output logic [DATA_W-1:0] val
);
  logic              ok_q, ok_d;
  logic [TAG_W-1:0]  tag_q, tag_d;
  logic [DATA_W-1:0] val_q, val_d;
  logic              en;
  logic              hit_ld, hit_wait;

  assign hit_ld   = cdb_valid && (cdb_tag == ld_tag);
  assign hit_wait = cdb_valid && (cdb_tag == tag_q) && !ok_q;

  always_comb begin
    ok_d  = ok_q;
    tag_d = tag_q;
    val_d = val_q;
    en    = 1'b0;
    if (load) begin
      en    = 1'b1;
      tag_d = ld_tag;
      if (!ld_pend) begin
        ok_d  = 1'b1;
        val_d = ld_val;
      end else if (hit_ld) begin
        ok_d  = 1'b1;
        val_d = cdb_data;
      end else begin
        ok_d  = 1'b0;
      end
    end else if (hit_wait) begin
      en    = 1'b1;
      ok_d  = 1'b1;
      val_d = cdb_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ok_q <= 1'b0;
    end else if (en) begin
      ok_q <= ok_d;
    end
  end

  always_ff @(posedge clk) begin
    if (en) begin
      tag_q <= tag_d;
      val_q <= val_d;
    end
  end

  assign ok  = ok_q;
  assign val = val_q;
endmodule

// File: rtl/rs_entry.sv
module rs_entry import rs_pkg::*; #(
  parameter int DATA_W = 32,
  parameter int TAG_W  = 4,
  parameter int OP_W   = 4,
  parameter int AGE_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              alloc,
  input  logic [OP_W-1:0]   d_op,
  input  logic [TAG_W-1:0]  d_dst,
  input  logic              d_a_pend,
  input  logic [TAG_W-1:0]  d_a_tag,
  input  logic [DATA_W-1:0] d_a_val,
  input  logic              d_b_pend,
  input  logic [TAG_W-1:0]  d_b_tag,
  input  logic [DATA_W-1:0] d_b_val,
  input  logic              cdb_valid,
  input  logic [TAG_W-1:0]  cdb_tag,
  input  logic [DATA_W-1:0] cdb_data,
  input  logic              take,
  output logic              busy,
  output logic              sent,
  output logic              ready,
  output logic [AGE_W-1:0]  age,
  output logic [OP_W-1:0]   op,
  output logic [TAG_W-1:0]  dst,
  output logic [DATA_W-1:0] a_val,
  output logic [DATA_W-1:0] b_val
);
  localparam logic [AGE_W-1:0] AGE_MAX = {AGE_W{1'b1}};

  st_phase_e         ph_q, ph_d;
  logic [AGE_W-1:0]  age_q, age_d;
  logic              age_en;
  logic [OP_W-1:0]   op_q;
  logic [TAG_W-1:0]  dst_q;
  logic              a_ok, b_ok;
  logic              own_done;

  assign own_done = cdb_valid && (cdb_tag == dst_q);

  always_comb begin
    ph_d = ph_q;
    if (flush) begin
      ph_d = ST_FREE;
    end else begin
      unique case (ph_q)
        ST_FREE: if (alloc)    ph_d = ST_WAIT;
        ST_WAIT: if (take)     ph_d = ST_SENT;
        ST_SENT: if (own_done) ph_d = ST_FREE;
        default:               ph_d = ST_FREE;
      endcase
    end
  end

  always_comb begin
    age_en = 1'b0;
    age_d  = age_q;
    if (alloc) begin
      age_en = 1'b1;
      age_d  = '0;
    end else if ((ph_q != ST_FREE) && (age_q != AGE_MAX)) begin
      age_en = 1'b1;
      age_d  = age_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= ST_FREE;
      age_q <= '0;
    end else begin
      ph_q <= ph_d;
      if (age_en) age_q <= age_d;
    end
  end

  always_ff @(posedge clk) begin
    if (alloc) begin
      op_q  <= d_op;
      dst_q <= d_dst;
    end
  end

  rs_operand #(.DATA_W(DATA_W), .TAG_W(TAG_W)) u_opa (
    .clk(clk), .rst_n(rst_n), .load(alloc),
    .ld_pend(d_a_pend), .ld_tag(d_a_tag), .ld_val(d_a_val),
    .cdb_valid(cdb_valid), .cdb_tag(cdb_tag), .cdb_data(cdb_data),
    .ok(a_ok), .val(a_val)
  );

  rs_operand #(.DATA_W(DATA_W), .TAG_W(TAG_W)) u_opb (
    .clk(clk), .rst_n(rst_n), .load(alloc),
    .ld_pend(d_b_pend), .ld_tag(d_b_tag), .ld_val(d_b_val),
    .cdb_valid(cdb_valid), .cdb_tag(cdb_tag), .cdb_data(cdb_data),
    .ok(b_ok), .val(b_val)
  );

  assign busy  = (ph_q != ST_FREE);
  assign sent  = (ph_q == ST_SENT);
  assign ready = (ph_q == ST_WAIT) && a_ok && b_ok;
  assign age   = age_q;
  assign op    = op_q;
  assign dst   = dst_q;
endmodule

// File: rtl/rs_pick.sv
module rs_pick #(
  parameter int N     = 4,
  parameter int AGE_W = 4
) (
  input  logic [N-1:0]       req,
  input  logic [N*AGE_W-1:0] ages,
  output logic [N-1:0]       grant,
  output logic               any
);
  logic [AGE_W-1:0] best;

  always_comb begin
    grant = '0;
    best  = '0;
    any   = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (req[i] && (!any || (ages[i*AGE_W +: AGE_W] > best))) begin
        grant    = '0;
        grant[i] = 1'b1;
        best     = ages[i*AGE_W +: AGE_W];
        any      = 1'b1;
      end
    end
  end
endmodule

// File: rtl/rs_array.sv
module rs_array import rs_pkg::*; #(
  parameter int N      = RS_N,
  parameter int DATA_W = RS_DATA_W,
  parameter int TAG_W  = RS_TAG_W,
  parameter int OP_W   = RS_OP_W,
  parameter int AGE_W  = RS_AGE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              rob_free,
  input  logic              disp_valid,
  output logic              disp_ready,
  input  logic [OP_W-1:0]   disp_op,
  input  logic [TAG_W-1:0]  disp_dst,
  input  logic              disp_a_pend,
  input  logic [TAG_W-1:0]  disp_a_tag,
  input  logic [DATA_W-1:0] disp_a_val,
  input  logic              disp_b_pend,
  input  logic [TAG_W-1:0]  disp_b_tag,
  input  logic [DATA_W-1:0] disp_b_val,
  input  logic              cdb_valid,
  input  logic [TAG_W-1:0]  cdb_tag,
  input  logic [DATA_W-1:0] cdb_data,
  output logic              fu_valid,
  input  logic              fu_ready,
  output logic [OP_W-1:0]   fu_op,
  output logic [DATA_W-1:0] fu_a,
  output logic [DATA_W-1:0] fu_b,
  output logic [TAG_W-1:0]  fu_dst
);
  logic [N-1:0]        st_busy, st_sent, st_ready;
  logic [N-1:0]        free_pick, alloc_vec, grant, take;
  logic [N*AGE_W-1:0]  st_age;
  logic [N*TAG_W-1:0]  st_dst;
  logic [N*OP_W-1:0]   st_op;
  logic [N*DATA_W-1:0] st_a, st_b;
  logic                free_any, found, pick_any, accept, fire;

  // lowest-numbered free station
  always_comb begin
    free_pick = '0;
    found     = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (!st_busy[i] && !found) begin
        free_pick[i] = 1'b1;
        found        = 1'b1;
      end
    end
  end

  assign free_any   = |(~st_busy);
  assign disp_ready = !flush && rob_free && free_any;
  assign accept     = disp_valid && disp_ready;
  assign alloc_vec  = accept ? free_pick : '0;

  rs_pick #(.N(N), .AGE_W(AGE_W)) u_pick (
    .req(st_ready), .ages(st_age), .grant(grant), .any(pick_any)
  );

  assign fu_valid = pick_any && !flush;
  assign fire     = fu_valid && fu_ready;
  assign take     = fire ? grant : '0;

  for (genvar g = 0; g < N; g++) begin : g_st
    rs_entry #(.DATA_W(DATA_W), .TAG_W(TAG_W), .OP_W(OP_W), .AGE_W(AGE_W)) u_ent (
      .clk(clk), .rst_n(rst_n), .flush(flush), .alloc(alloc_vec[g]),
      .d_op(disp_op), .d_dst(disp_dst),
      .d_a_pend(disp_a_pend), .d_a_tag(disp_a_tag), .d_a_val(disp_a_val),
      .d_b_pend(disp_b_pend), .d_b_tag(disp_b_tag), .d_b_val(disp_b_val),
      .cdb_valid(cdb_valid), .cdb_tag(cdb_tag), .cdb_data(cdb_data),
      .take(take[g]),
      .busy(st_busy[g]), .sent(st_sent[g]), .ready(st_ready[g]),
      .age(st_age[g*AGE_W +: AGE_W]),
      .op(st_op[g*OP_W +: OP_W]),
      .dst(st_dst[g*TAG_W +: TAG_W]),
      .a_val(st_a[g*DATA_W +: DATA_W]),
      .b_val(st_b[g*DATA_W +: DATA_W])
    );
  end

  // one-hot mux of the granted station
  always_comb begin
    fu_op  = '0;
    fu_dst = '0;
    fu_a   = '0;
    fu_b   = '0;
    for (int i = 0; i < N; i++) begin
      if (grant[i]) begin
        fu_op  = fu_op  | st_op[i*OP_W +: OP_W];
        fu_dst = fu_dst | st_dst[i*TAG_W +: TAG_W];
        fu_a   = fu_a   | st_a[i*DATA_W +: DATA_W];
        fu_b   = fu_b   | st_b[i*DATA_W +: DATA_W];
      end
    end
  end
endmodule

// File: rtl/rs_array_chk.sv
module rs_array_chk #(
  parameter int N     = 4,
  parameter int TAG_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             flush,
  input logic             rob_free,
  input logic             disp_ready,
  input logic             fu_valid,
  input logic             fu_ready,
  input logic             cdb_valid,
  input logic [TAG_W-1:0] cdb_tag,
  input logic [N-1:0]     st_busy,
  input logic [N-1:0]     st_sent,
  input logic [N-1:0]     grant,
  input logic [N*TAG_W-1:0] st_dst
);
  p_disp_gate_r1: assert property (@(posedge clk) disable iff (!rst_n)
    disp_ready |-> (rob_free && !flush));

  p_full_block_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (&st_busy) |-> !disp_ready);

  p_empty_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(|st_busy) |-> !fu_valid);

  p_one_grant_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  p_flush_block_r9: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> (!disp_ready && !fu_valid));

  p_flush_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !(|st_busy));

  for (genvar i = 0; i < N; i++) begin : g_st
    p_taken_once_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (fu_valid && fu_ready && grant[i]) |=> st_sent[i]);

    p_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (st_sent[i] && !flush && cdb_valid && (cdb_tag == st_dst[i*TAG_W +: TAG_W]))
      |=> !st_busy[i]);
  end
endmodule

bind rs_array rs_array_chk #(.N(N), .TAG_W(TAG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .flush(flush), .rob_free(rob_free),
  .disp_ready(disp_ready), .fu_valid(fu_valid), .fu_ready(fu_ready),
  .cdb_valid(cdb_valid), .cdb_tag(cdb_tag),
  .st_busy(st_busy), .st_sent(st_sent), .grant(grant), .st_dst(st_dst)
);

// File: tb/tb_rs_array.sv
module tb_rs_array;
  localparam int N = 4, DW = 32, TW = 4, OW = 4, AW = 4;
  localparam int AGE_MAX = (1 << AW) - 1;

  logic clk, rst_n, flush, rob_free, disp_valid, disp_ready;
  logic [OW-1:0] disp_op;
  logic [TW-1:0] disp_dst, disp_a_tag, disp_b_tag, cdb_tag, fu_dst;
  logic disp_a_pend, disp_b_pend, cdb_valid, fu_valid, fu_ready;
  logic [DW-1:0] disp_a_val, disp_b_val, cdb_data, fu_a, fu_b;
  logic [OW-1:0] fu_op;

  rs_array #(.N(N), .DATA_W(DW), .TAG_W(TW), .OP_W(OW), .AGE_W(AW)) dut (.*);

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int n_checks = 0, n_fail = 0;
  bit done = 0;

  // reference model
  bit      m_busy[N], m_sent[N], m_aok[N], m_bok[N];
  int      m_age[N];
  logic [OW-1:0] m_op[N];
  logic [TW-1:0] m_dst[N], m_atag[N], m_btag[N];
  logic [DW-1:0] m_aval[N], m_bval[N];
  bit e_dr, e_fv;
  int e_sel;
  logic [TW-1:0] dst_ctr;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic sample_check();
    int nrdy;
    bit any_free;
    #1;
    any_free = 0;
    nrdy = 0;
    e_sel = -1;
    for (int i = 0; i < N; i++) begin
      if (!m_busy[i]) any_free = 1;
      if (m_busy[i] && !m_sent[i] && m_aok[i] && m_bok[i]) begin
        nrdy++;
        if (e_sel < 0 || m_age[i] > m_age[e_sel]) e_sel = i;
      end
    end
    e_dr = !flush && rob_free && any_free;
    e_fv = (e_sel >= 0) && !flush;
    check("R1", disp_ready, e_dr);
    check("R5", fu_valid, e_fv);
    if (e_fv) begin
      check(nrdy > 1 ? "R6" : "R2", fu_dst, m_dst[e_sel]);
      check("R2", fu_op, m_op[e_sel]);
      check("R3", fu_a, m_aval[e_sel]);
      check("R3", fu_b, m_bval[e_sel]);
    end
  endtask

  task automatic advance();
    int slot;
    bit accept;
    accept = disp_valid && e_dr;
    slot = -1;
    for (int i = 0; i < N; i++) if (!m_busy[i] && slot < 0) slot = i;
    for (int i = 0; i < N; i++) begin
      if (flush) begin
        m_busy[i] = 0;
      end else if (m_busy[i]) begin
        if (m_sent[i] && cdb_valid && cdb_tag == m_dst[i]) m_busy[i] = 0;
        if (!m_sent[i] && e_fv && fu_ready && e_sel == i) m_sent[i] = 1;
        if (!m_aok[i] && cdb_valid && cdb_tag == m_atag[i]) begin m_aok[i] = 1; m_aval[i] = cdb_data; end
        if (!m_bok[i] && cdb_valid && cdb_tag == m_btag[i]) begin m_bok[i] = 1; m_bval[i] = cdb_data; end
        if (m_age[i] < AGE_MAX) m_age[i]++;
      end
    end
    if (accept) begin
      m_busy[slot] = 1; m_sent[slot] = 0; m_age[slot] = 0;
      m_op[slot] = disp_op; m_dst[slot] = disp_dst;
      m_atag[slot] = disp_a_tag; m_btag[slot] = disp_b_tag;
      if (!disp_a_pend) begin m_aok[slot] = 1; m_aval[slot] = disp_a_val; end
      else if (cdb_valid && cdb_tag == disp_a_tag) begin m_aok[slot] = 1; m_aval[slot] = cdb_data; end
      else m_aok[slot] = 0;
      if (!disp_b_pend) begin m_bok[slot] = 1; m_bval[slot] = disp_b_val; end
      else if (cdb_valid && cdb_tag == disp_b_tag) begin m_bok[slot] = 1; m_bval[slot] = cdb_data; end
      else m_bok[slot] = 0;
      dst_ctr = dst_ctr + 1'b1;
    end
    @(negedge clk);
  endtask

  task automatic idle();
    flush = 0; rob_free = 1; disp_valid = 0; disp_op = '0; disp_dst = '0;
    disp_a_pend = 0; disp_a_tag = '0; disp_a_val = '0;
    disp_b_pend = 0; disp_b_tag = '0; disp_b_val = '0;
    cdb_valid = 0; cdb_tag = '0; cdb_data = '0; fu_ready = 0;
  endtask

  task automatic disp(input logic [TW-1:0] dst, input bit ap, input logic [TW-1:0] at,
                      input logic [DW-1:0] av, input logic [DW-1:0] bv);
    disp_valid = 1; disp_op = dst + 4'd1; disp_dst = dst;
    disp_a_pend = ap; disp_a_tag = at; disp_a_val = av;
    disp_b_pend = 0; disp_b_val = bv;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  initial begin : main
    void'($urandom(32'h5eed_0042));
    for (int i = 0; i < N; i++) begin m_busy[i] = 0; m_sent[i] = 0; m_age[i] = 0; end
    dst_ctr = '0;
    rst_n = 0;
    idle();
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R10: empty after reset
    sample_check();
    check("R10", disp_ready, 1'b1);
    check("R10", fu_valid, 1'b0);
    advance();
    rob_free = 0;
    sample_check();
    check("R1", disp_ready, 1'b0);
    check("R10", fu_valid, 1'b0);
    advance();

    // R4: operand tag broadcast in the dispatch cycle
    idle();
    disp(4'd5, 1, 4'd9, '0, 32'h5);
    cdb_valid = 1; cdb_tag = 4'd9; cdb_data = 32'hAAAA;
    sample_check(); advance();
    idle();
    sample_check();
    check("R4", fu_valid, 1'b1);
    check("R4", fu_a, 32'hAAAA);
    advance();
    sample_check();
    check("R7", fu_valid, 1'b1);
    fu_ready = 1;
    advance();
    idle();
    sample_check();
    check("R7", fu_valid, 1'b0);
    advance();

    // R9: flush
    flush = 1;
    sample_check();
    check("R9", disp_ready, 1'b0);
    advance();
    idle();
    sample_check();
    check("R9", disp_ready, 1'b1);
    advance();

    // fill all stations waiting on tag 12, then wake them together
    for (int k = 0; k < N; k++) begin
      idle();
      disp(k[TW-1:0], 1, 4'd12, '0, 32'h100 + k);
      sample_check(); advance();
    end
    idle();
    sample_check();
    check("R1", disp_ready, 1'b0);
    check("R5", fu_valid, 1'b0);
    cdb_valid = 1; cdb_tag = 4'd12; cdb_data = 32'h77;
    advance();
    idle();
    sample_check();
    check("R5", fu_valid, 1'b1);
    check("R6", fu_dst, 4'd0);
    check("R3", fu_a, 32'h77);
    fu_ready = 1;
    advance();
    idle();
    sample_check();
    check("R6", fu_dst, 4'd1);
    cdb_valid = 1; cdb_tag = 4'd0; cdb_data = 32'h1;
    advance();
    idle();
    sample_check();
    check("R8", disp_ready, 1'b1);
    advance();
    flush = 1;
    sample_check(); advance();
    idle();
    dst_ctr = '0;

    // constrained random traffic
    for (int c = 0; c < 4000; c++) begin
      int ns;
      logic [TW-1:0] sl[N];
      flush      = ($urandom % 60) == 0;
      rob_free   = ($urandom % 8) != 0;
      disp_valid = ($urandom % 4) != 0;
      disp_op    = $urandom;
      disp_dst   = dst_ctr;
      disp_a_pend = $urandom % 2;
      disp_a_tag  = ($urandom % 2) ? dst_ctr - 4'd1 - 4'($urandom % 4) : 4'($urandom);
      disp_a_val  = $urandom;
      disp_b_pend = $urandom % 2;
      disp_b_tag  = dst_ctr - 4'd1 - 4'($urandom % 5);
      disp_b_val  = $urandom;
      ns = 0;
      for (int i = 0; i < N; i++) if (m_busy[i] && m_sent[i]) begin sl[ns] = m_dst[i]; ns++; end
      cdb_valid = $urandom % 2;
      cdb_tag   = (ns > 0 && ($urandom % 10) < 6) ? sl[$urandom % ns]
                                                   : dst_ctr - 4'd1 - 4'($urandom % 6);
      cdb_data  = $urandom;
      fu_ready  = ($urandom % 3) != 0;
      sample_check();
      advance();
    end

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule